// File: doc/BRIEF.md
# Two-Wire Register-Pointer Slave

This block is a slave controller for a two-wire serial bus (I2C / SMBus compatible). It gives an external host access to a bank of 16-bit registers that lives elsewhere in the chip. The block over-samples the bus clock and data lines with the system clock and finds START and STOP conditions. It matches a 7-bit address whose two low bits come from a strap code. It drives the data line open-drain through a single pull-low enable.

A write transaction always carries a pointer byte first. That byte selects the register, and it is still in force in later transactions. Zero, one, two or more data bytes may follow the pointer. A read transaction returns the high byte and then the low byte of the register that the pointer selects. The chip side sees a plain parallel port: the pointer as the register address, a one-cycle write strobe with 16-bit write data, and a 16-bit read data input. A watchdog on the bus clock drops any transaction that has stalled, so a hung host cannot hold the data line low for ever.

Top module: `smb_regptr_slave`

## Requirements
- R1: The slave responds only to the address `10111` followed by the two strap bits (strap bit 1 first). A matching address byte is acknowledged by pulling SDA low during the ninth clock. A non-matching address gets no acknowledge, and the slave leaves SDA released until the next START.
- R2: The strap code is captured at every START, so a new code takes effect from the next transaction.
- R3: In a write, the first byte after the address loads the pointer. The next two bytes are the high byte and then the low byte of the register data. Each of these bytes is acknowledged. After the second data byte has been acknowledged, exactly one single-cycle `reg_wr` pulse presents the pointer on `reg_addr` and the 16-bit value on `reg_wdata`.
- R4: A write that ends after the pointer byte updates `reg_addr` and produces no `reg_wr`.
- R5: A read returns the high byte and then the low byte of the pointed register, MSB first. The pointer keeps its value across transactions and changes only while a transaction is active.
- R6: A host that keeps acknowledging past the low byte receives the same register again, high byte and low byte in turn, from the value captured at the address phase.
- R7: After a NACK from the host, the slave releases SDA and drives nothing more until a new START. Bytes clocked in that gap read as 0xFF.
- R8: A write that stops after only one data byte leaves the register untouched (no `reg_wr`).
- R9: A pointer at or above `NUM_REGS` reads as 0x0000 and does not produce `reg_wr`. The pointer itself is still updated.
- R10: If SCL makes no transition for `TIMEOUT_CYC` clock cycles while a transaction is active, the slave releases SDA and goes idle. It then accepts the next START normally.
- R11: Synchronous reset leaves SDA released, `reg_wr` low and the pointer at 0x00.
- R12: Write bytes after the second data byte are acknowledged and discarded. They produce no further `reg_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to over-sample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| strap_i | input | 2 | Encoded address strap, sampled at each START |
| sda_oe | output | 1 | Pull-low enable for the open-drain data line |
| reg_addr | output | 8 | Current register pointer |
| reg_wr | output | 1 | One-cycle register write strobe |
| reg_wdata | output | 16 | Register write data, high byte first on the bus |
| reg_rdata | input | 16 | Read data of the register at `reg_addr` |

## Verification
A wrong bit counter or phase register appears at the ports within one byte time. An acknowledge lands on the wrong clock, or a read byte comes out shifted, and the bench catches this on the very next byte it samples. A pointer or write-phase fault first shows up as a missing, extra or misdirected `reg_wr` strobe. The write scoreboard reports that at the end of the transaction. A stale read capture or an error in the wrap rule is only visible on the next read, so every write and pointer change is followed by a readback. A timer fault shows up as SDA still held low after the stall window, or as a slave that does not answer the following START.

// File: rtl/smb_regptr_pkg.sv
package smb_regptr_pkg;

    localparam int          PTR_W     = 8;
    localparam int          REG_W     = 16;
    localparam logic [4:0]  ADDR_BASE = 5'b10111;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK
    } xfer_st_e;

    typedef enum logic [1:0] {
        PH_PTR,
        PH_MSB,
        PH_LSB,
        PH_DROP
    } wr_phase_e;

    typedef struct packed {
        logic sda;
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_ev_t;

    function automatic logic [6:0] slave_addr(input logic [1:0] code);
        return {ADDR_BASE, code};
    endfunction

endpackage

// File: rtl/smb_bus_sense.sv
module smb_bus_sense
    import smb_regptr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev,
    output logic    scl_lvl
);
    localparam int N = SYNC_STAGES + 1;

    logic [N-1:0] scl_sh;
    logic [N-1:0] sda_sh;
    logic         scl_now, scl_old, sda_now, sda_old;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
        end else begin
            scl_sh <= {scl_sh[N-2:0], scl_i};
            sda_sh <= {sda_sh[N-2:0], sda_i};
        end
    end

    assign scl_now = scl_sh[N-2];
    assign scl_old = scl_sh[N-1];
    assign sda_now = sda_sh[N-2];
    assign sda_old = sda_sh[N-1];

    always_comb begin
        ev.sda   = sda_now;
        ev.start = scl_now && scl_old && sda_old && !sda_now;
        ev.stop  = scl_now && scl_old && !sda_old && sda_now;
        ev.rise  = scl_now && !scl_old;
        ev.fall  = !scl_now && scl_old;
    end

    assign scl_lvl = scl_now;

endmodule

// File: rtl/smb_idle_timer.sv
module smb_idle_timer #(
    parameter int TIMEOUT_CYC = 5_600_000
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic kick,
    output logic expire
);
    localparam int CW = $clog2(TIMEOUT_CYC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !active || kick) begin
            cnt <= '0;
        end else if (!expire) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expire = active && !kick && (cnt == CW'(TIMEOUT_CYC - 1));

endmodule

// File: rtl/smb_xfer_fsm.sv
module smb_xfer_fsm
    import smb_regptr_pkg::*;
#(
    parameter int NUM_REGS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_ev_t          ev,
    input  logic [1:0]       strap,
    input  logic             expire,
    input  logic [REG_W-1:0] rd_data,
    output logic             sda_oe,
    output logic [PTR_W-1:0] ptr,
    output logic             wr_en,
    output logic [REG_W-1:0] wr_data,
    output logic             active
);
    xfer_st_e   st;
    wr_phase_e  wph;
    logic [3:0] cnt;
    logic [7:0] shreg;
    logic [7:0] msb_hold;
    logic [REG_W-1:0] rd_buf;
    logic [1:0] code;
    logic       rw;
    logic       rd_lsb;
    logic       mack;
    logic       ptr_ok;
    logic [7:0] rd_next;

    assign ptr_ok  = (32'(ptr) < NUM_REGS);
    assign active  = (st != ST_IDLE);
    assign rd_next = rd_lsb ? rd_buf[7:0] : rd_buf[15:8];

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            wph      <= PH_PTR;
            cnt      <= '0;
            shreg    <= '0;
            msb_hold <= '0;
            rd_buf   <= '0;
            code     <= '0;
            rw       <= 1'b0;
            rd_lsb   <= 1'b0;
            mack     <= 1'b0;
            sda_oe   <= 1'b0;
            ptr      <= '0;
            wr_en    <= 1'b0;
            wr_data  <= '0;
        end else begin
            wr_en <= 1'b0;
            if (expire) begin
                st     <= ST_IDLE;
                sda_oe <= 1'b0;
            end else if (ev.start) begin
                st     <= ST_ADDR;
                cnt    <= '0;
                code   <= strap;
                sda_oe <= 1'b0;
            end else if (ev.stop) begin
                st     <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                unique case (st)
                    ST_IDLE: ;
                    ST_ADDR, ST_WR_BYTE: begin
                        if (ev.rise && cnt != 4'd8) begin
                            shreg <= {shreg[6:0], ev.sda};
                            cnt   <= cnt + 4'd1;
                        end else if (ev.fall && cnt == 4'd8) begin
                            cnt <= '0;
                            if (st == ST_ADDR) begin
                                if (shreg[7:1] == slave_addr(code)) begin
                                    st     <= ST_ADDR_ACK;
                                    sda_oe <= 1'b1;
                                    rw     <= shreg[0];
                                    wph    <= PH_PTR;
                                    rd_buf <= ptr_ok ? rd_data : '0;
                                    rd_lsb <= 1'b0;
                                end else begin
                                    st <= ST_IDLE;
                                end
                            end else begin
                                st     <= ST_WR_ACK;
                                sda_oe <= 1'b1;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (ev.fall) begin
                            cnt <= '0;
                            if (rw) begin
                                st     <= ST_RD_BYTE;
                                shreg  <= rd_next;
                                sda_oe <= !rd_next[7];
                                rd_lsb <= !rd_lsb;
                            end else begin
                                st     <= ST_WR_BYTE;
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_WR_ACK: begin
                        if (ev.fall) begin
                            st     <= ST_WR_BYTE;
                            sda_oe <= 1'b0;
                            unique case (wph)
                                PH_PTR: begin
                                    ptr <= shreg;
                                    wph <= PH_MSB;
                                end
                                PH_MSB: begin
                                    msb_hold <= shreg;
                                    wph      <= PH_LSB;
                                end
                                PH_LSB: begin
                                    wr_en   <= ptr_ok;
                                    wr_data <= {msb_hold, shreg};
                                    wph     <= PH_DROP;
                                end
                                PH_DROP: ;
                            endcase
                        end
                    end
                    ST_RD_BYTE: begin
                        if (ev.fall) begin
                            if (cnt == 4'd7) begin
                                st     <= ST_RD_ACK;
                                sda_oe <= 1'b0;
                                cnt    <= '0;
                            end else begin
                                shreg  <= {shreg[6:0], 1'b0};
                                sda_oe <= !shreg[6];
                                cnt    <= cnt + 4'd1;
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (ev.rise) begin
                            mack <= !ev.sda;
                        end else if (ev.fall) begin
                            if (mack) begin
                                st     <= ST_RD_BYTE;
                                shreg  <= rd_next;
                                sda_oe <= !rd_next[7];
                                rd_lsb <= !rd_lsb;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/smb_regptr_slave.sv
module smb_regptr_slave
    import smb_regptr_pkg::*;
#(
    parameter int NUM_REGS    = 8,
    parameter int TIMEOUT_CYC = 5_600_000,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        scl_i,
    input  logic        sda_i,
    input  logic [1:0]  strap_i,
    output logic        sda_oe,
    output logic [7:0]  reg_addr,
    output logic        reg_wr,
    output logic [15:0] reg_wdata,
    input  logic [15:0] reg_rdata
);
    bus_ev_t bus_ev;
    logic    scl_lvl;
    logic    tmo_expire;
    logic    xfer_active;

    smb_bus_sense #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sense (
        .clk    (clk),
        .rst    (rst),
        .scl_i  (scl_i),
        .sda_i  (sda_i),
        .ev     (bus_ev),
        .scl_lvl(scl_lvl)
    );

    smb_idle_timer #(
        .TIMEOUT_CYC(TIMEOUT_CYC)
    ) u_timer (
        .clk   (clk),
        .rst   (rst),
        .active(xfer_active),
        .kick  (bus_ev.rise || bus_ev.fall),
        .expire(tmo_expire)
    );

    smb_xfer_fsm #(
        .NUM_REGS(NUM_REGS)
    ) u_fsm (
        .clk    (clk),
        .rst    (rst),
        .ev     (bus_ev),
        .strap  (strap_i),
        .expire (tmo_expire),
        .rd_data(reg_rdata),
        .sda_oe (sda_oe),
        .ptr    (reg_addr),
        .wr_en  (reg_wr),
        .wr_data(reg_wdata),
        .active (xfer_active)
    );

endmodule

// File: rtl/smb_regptr_slave_chk.sv
module smb_regptr_slave_chk #(
    parameter int NUM_REGS = 8
) (
    input logic       clk,
    input logic       rst,
    input logic       scl_lvl,
    input logic       sda_oe,
    input logic [7:0] reg_addr,
    input logic       reg_wr,
    input logic       expire,
    input logic       active
);
    logic rst_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst_q) begin
            p_reset_state_r11: assert (!sda_oe && !reg_wr && reg_addr == 8'h00)
                else $error("reset state wrong");
        end
    end

    p_single_strobe_r3: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> !reg_wr);

    p_no_strobe_unmapped_r9: assert property (@(posedge clk) disable iff (rst)
        reg_wr |-> (32'(reg_addr) < NUM_REGS));

    p_ptr_holds_idle_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(reg_addr) |-> $past(active));

    p_sda_moves_scl_low_r5: assert property (@(posedge clk) disable iff (rst)
        (!$stable(sda_oe) && !$past(expire)) |-> !scl_lvl);

    p_idle_released_r7: assert property (@(posedge clk) disable iff (rst)
        !active |-> !sda_oe);

    p_timeout_release_r10: assert property (@(posedge clk) disable iff (rst)
        expire |=> (!sda_oe && !active));

endmodule

bind smb_regptr_slave smb_regptr_slave_chk #(
    .NUM_REGS(NUM_REGS)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .scl_lvl (scl_lvl),
    .sda_oe  (sda_oe),
    .reg_addr(reg_addr),
    .reg_wr  (reg_wr),
    .expire  (tmo_expire),
    .active  (xfer_active)
);

// File: tb/smb_regptr_slave_test.sv
`timescale 1ns/1ps
module smb_regptr_slave_test;
    localparam int NREG = 8;
    localparam int TMO  = 200;
    localparam int T    = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic [1:0]  strap = 2'b00;
    logic        sda_oe;
    logic        sda_ln;
    logic [7:0]  reg_addr;
    logic        reg_wr;
    logic [15:0] reg_wdata;
    logic [15:0] reg_rdata;
    logic [15:0] rf [NREG];

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    logic [7:0]  q_addr [$];
    logic [15:0] q_data [$];

    always #2.5 clk = ~clk;

    assign sda_ln    = sda_m & ~sda_oe;
    assign reg_rdata = (reg_addr < 8'(NREG)) ? rf[reg_addr[2:0]] : 16'hDEAD;

    smb_regptr_slave #(
        .NUM_REGS(NREG),
        .TIMEOUT_CYC(TMO),
        .SYNC_STAGES(2)
    ) uut (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (scl_m),
        .sda_i    (sda_ln),
        .strap_i  (strap),
        .sda_oe   (sda_oe),
        .reg_addr (reg_addr),
        .reg_wr   (reg_wr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    function automatic logic [15:0] init_val(input int i);
        return 16'(16'h1000 * i + 16'h00C0 + i);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // register file model and write scoreboard monitor
    always @(negedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) rf[i] <= init_val(i);
        end else if (reg_wr) begin
            n_chk++;
            if (q_addr.size() == 0) begin
                n_err++;
                $display("FAIL R3: actual unexpected write %h<=%h expected none", reg_addr, reg_wdata);
            end else begin
                automatic logic [7:0]  ea = q_addr.pop_front();
                automatic logic [15:0] ed = q_data.pop_front();
                if (ea !== reg_addr || ed !== reg_wdata) begin
                    n_err++;
                    $display("FAIL R3: actual %h<=%h expected %h<=%h", reg_addr, reg_wdata, ea, ed);
                end
            end
            if (reg_addr < 8'(NREG)) rf[reg_addr[2:0]] <= reg_wdata;
        end
    end

    task automatic expect_wr(input logic [7:0] a, input logic [15:0] d);
        q_addr.push_back(a);
        q_data.push_back(d);
    endtask

    task automatic tick();
        repeat (T) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; tick();
        sda_m = 1'b0; tick();
        scl_m = 1'b0; tick();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick();
        scl_m = 1'b1; tick();
        sda_m = 1'b1; tick();
    endtask

    task automatic put_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick();
            scl_m = 1'b1; tick();
            scl_m = 1'b0;
        end
        sda_m = 1'b1; tick();
        scl_m = 1'b1; tick();
        ack = !sda_ln;
        scl_m = 1'b0; tick();
    endtask

    task automatic get_byte(output logic [7:0] b, input logic ack_it);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick();
            scl_m = 1'b1; tick();
            b[i] = sda_ln;
            scl_m = 1'b0;
        end
        sda_m = !ack_it; tick();
        scl_m = 1'b1; tick();
        scl_m = 1'b0; tick();
        sda_m = 1'b1;
    endtask

    // two-byte read at the current pointer, checked against exp
    task automatic read_reg(input logic [6:0] a, input logic [15:0] exp, input string req);
        logic ack;
        logic [7:0] hi, lo;
        bus_start();
        put_byte({a, 1'b1}, ack);
        chk(req, 32'(ack), 32'd1);
        get_byte(hi, 1'b1);
        get_byte(lo, 1'b0);
        bus_stop();
        chk(req, {16'h0, hi, lo}, {16'h0, exp});
    endtask

    initial begin
        logic ack;
        logic [7:0] b0, b1, b2, b3;
        repeat (5) @(negedge clk);
        // R11 reset state
        chk("R11", {23'h0, sda_oe, reg_wr, reg_addr}, 32'h0);
        rst = 1'b0;
        tick();

        // R1 / R3: write pointer 3 and data A55A at strap 00 (address 1011100)
        bus_start();
        put_byte({7'h5C, 1'b0}, ack); chk("R1", 32'(ack), 32'd1);
        expect_wr(8'h03, 16'hA55A);
        put_byte(8'h03, ack); chk("R3", 32'(ack), 32'd1);
        put_byte(8'hA5, ack); chk("R3", 32'(ack), 32'd1);
        put_byte(8'h5A, ack); chk("R3", 32'(ack), 32'd1);
        bus_stop();
        chk("R3", 32'(reg_addr), 32'h03);

        // R1: wrong address gets no acknowledge and no later drive
        bus_start();
        put_byte({7'h5D, 1'b0}, ack); chk("R1", 32'(ack), 32'd0);
        put_byte(8'h00, ack);         chk("R1", 32'(ack), 32'd0);
        bus_stop();
        chk("R1", 32'(reg_addr), 32'h03);

        // R2: strap 10 moves the address to 1011110
        strap = 2'b10;
        bus_start();
        put_byte({7'h5C, 1'b1}, ack); chk("R2", 32'(ack), 32'd0);
        bus_stop();
        read_reg(7'h5E, 16'hA55A, "R2");
        strap = 2'b00;

        // R5: pointer persists, repeated read without pointer write
        read_reg(7'h5C, 16'hA55A, "R5");

        // R4: pointer-only write
        bus_start();
        put_byte({7'h5C, 1'b0}, ack);
        put_byte(8'h05, ack); chk("R4", 32'(ack), 32'd1);
        bus_stop();
        chk("R4", 32'(reg_addr), 32'h05);
        read_reg(7'h5C, init_val(5), "R4");

        // R6: reading past the low byte alternates high/low of same register
        bus_start();
        put_byte({7'h5C, 1'b1}, ack);
        get_byte(b0, 1'b1);
        get_byte(b1, 1'b1);
        get_byte(b2, 1'b1);
        get_byte(b3, 1'b0);
        bus_stop();
        chk("R6", {b0, b1, b2, b3}, {init_val(5), init_val(5)});

        // R7: NACK after the first byte, slave stays off the line
        bus_start();
        put_byte({7'h5C, 1'b1}, ack);
        get_byte(b0, 1'b0);
        chk("R7", 32'(b0), 32'(init_val(5) >> 8));
        chk("R7", 32'(sda_oe), 32'd0);
        get_byte(b1, 1'b0);
        chk("R7", 32'(b1), 32'hFF);
        bus_stop();

        // R8: one data byte only, register untouched
        bus_start();
        put_byte({7'h5C, 1'b0}, ack);
        put_byte(8'h02, ack);
        put_byte(8'hEE, ack); chk("R8", 32'(ack), 32'd1);
        bus_stop();
        read_reg(7'h5C, init_val(2), "R8");

        // R9: unmapped pointer, write ignored, reads zero
        bus_start();
        put_byte({7'h5C, 1'b0}, ack);
        put_byte(8'h20, ack);
        put_byte(8'h12, ack);
        put_byte(8'h34, ack); chk("R9", 32'(ack), 32'd1);
        bus_stop();
        chk("R9", 32'(reg_addr), 32'h20);
        read_reg(7'h5C, 16'h0000, "R9");

        // R12: extra bytes acknowledged and discarded
        bus_start();
        put_byte({7'h5C, 1'b0}, ack);
        expect_wr(8'h01, 16'h9ABC);
        put_byte(8'h01, ack);
        put_byte(8'h9A, ack);
        put_byte(8'hBC, ack);
        put_byte(8'hDE, ack); chk("R12", 32'(ack), 32'd1);
        put_byte(8'hF0, ack); chk("R12", 32'(ack), 32'd1);
        bus_stop();
        read_reg(7'h5C, 16'h9ABC, "R12");

        // R10: host stalls with SCL low while the slave acknowledges
        bus_start();
        for (int i = 7; i >= 0; i--) begin
            sda_m = ((8'hB8 >> i) & 8'h01) != 0; tick();
            scl_m = 1'b1; tick();
            scl_m = 1'b0;
        end
        sda_m = 1'b1; tick();
        chk("R10", 32'(sda_oe), 32'd1);
        repeat (TMO + 40) @(negedge clk);
        chk("R10", 32'(sda_oe), 32'd0);
        chk("R10", 32'(sda_ln), 32'd1);
        read_reg(7'h5C, 16'h9ABC, "R10");

        tick();
        chk("R3", 32'(q_addr.size()), 32'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule